// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level Interrupts

This block buffers audio samples between a processor-side data port and the serial shifters of an audio link. It has one queue per direction. The transmit queue takes 32-bit words from software and hands them to the serializer one at a time, on request. The receive queue collects words from the deserializer until software pops them. Each side reports its fill state as a count: the transmit side as free entries, the receive side as words available.

A small status unit holds three sticky event bits. They are transmit underrun, transmit threshold reached and receive data present. Software clears each bit by writing a one to it. An enable mask gates the bits onto a single interrupt line. Two further enable bits drive one request line per direction for a DMA engine.

Each direction has a flush input that empties its queue. The serial shifters, the DMA engine and the register bus are outside the block; plain valid/ready strobes stand in for them.

Top module: `audio_fifo_irq`

## Requirements
- R1: After reset `tx_free` equals TX_DEPTH (128), `rx_avail` is 0, `sts` is 0, `irq` is 0, `tx_word` is 0 and `tx_wready` is 1.
- R2: Transmit words leave in the order written. `tx_free` (8 bits) equals TX_DEPTH minus occupancy. When the queue is full, `tx_wready` is 0 and writes are ignored. A `tx_req` on a non-empty queue places the oldest word on `tx_word` one cycle later.
- R3: Received words are popped in arrival order. `rx_rdata` shows the oldest word while `rx_rvalid` is 1, and `rx_avail` (6 bits) counts them. A word that arrives when RX_DEPTH (32) words are held is dropped. A pop on an empty queue has no effect.
- R4: While `tx_flush` is high, the transmit queue is emptied within one cycle and writes are ignored. `rx_flush` does the same for the receive queue. Neither flush sets any status bit.
- R5: A `tx_req` while the transmit queue is empty (and not flushing) sets `sts[6]` (underrun) and drives `tx_word` to zero on the next cycle.
- R6: A serializer pull that leaves the free count greater than or equal to `tx_level` sets `sts[4]`.
- R7: `sts[0]` is set in every cycle in which the receive queue holds at least one word and `rx_flush` is low.
- R8: When `sts_clr_we` is high, each `sts` bit whose `sts_clr` bit is 1 is cleared on the next edge, unless its set condition holds in that same cycle (set wins). `sts` bits 7, 5, 3, 2 and 1 always read 0.
- R9: `irq` is high exactly when some bit among `sts[6]`, `sts[4]` and `sts[0]` is 1 and the `irq_en` bit at the same position is 1.
- R10: `tx_drq` is high when `irq_en[7]` is 1 and `tx_free` is at least `tx_level`. `rx_drq` is high when `irq_en[3]` is 1 and `rx_avail` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | 7 | Transmit free-entry threshold |
| irq_en | input | 8 | Bit 6/4/0 status enables, bit 7 TX request enable, bit 3 RX request enable |
| tx_flush | input | 1 | Empty the transmit queue while high |
| rx_flush | input | 1 | Empty the receive queue while high |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 8 | Write-one-to-clear mask |
| sts | output | 8 | Sticky status: 6 underrun, 4 TX threshold, 0 RX data |
| irq | output | 1 | Interrupt line |
| tx_drq | output | 1 | Transmit DMA request |
| rx_drq | output | 1 | Receive DMA request |
| tx_wvalid | input | 1 | Transmit word write strobe |
| tx_wdata | input | 32 | Transmit word |
| tx_wready | output | 1 | Transmit queue can accept a word |
| tx_free | output | 8 | Free transmit entries |
| tx_req | input | 1 | Serializer asks for the next word |
| tx_word | output | 32 | Word handed to the serializer |
| rx_in_valid | input | 1 | Deserializer word strobe |
| rx_in_data | input | 32 | Deserialized word |
| rx_rdata | output | 32 | Oldest received word |
| rx_rvalid | output | 1 | Receive word present |
| rx_rready | input | 1 | Pop one received word |
| rx_avail | output | 6 | Received words held |

## Verification
The hardest case to reach from the ports is a status bit cleared in the same cycle that its source sets it again. Only then does the set-wins ordering show. The bench drains the transmit queue and then asserts a serializer request and a clear of the underrun bit in the same cycle. Both full boundaries are also reached: 128 transmit words are written and 32 receive words are injected, then one more word is offered to each queue to check that it is refused. A flush is issued together with a full status clear. This checks that a queue still holding data leaves no status behind after the flush.

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq #(
  parameter int DW       = 32,
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 32,
  parameter int FREE_W   = 8,
  parameter int AVAIL_W  = 6,
  parameter int LVL_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [7:0]         irq_en,
  input  logic               tx_flush,
  input  logic               rx_flush,
  input  logic               sts_clr_we,
  input  logic [7:0]         sts_clr,
  output logic [7:0]         sts,
  output logic               irq,
  output logic               tx_drq,
  output logic               rx_drq,
  input  logic               tx_wvalid,
  input  logic [DW-1:0]      tx_wdata,
  output logic               tx_wready,
  output logic [FREE_W-1:0]  tx_free,
  input  logic               tx_req,
  output logic [DW-1:0]      tx_word,
  input  logic               rx_in_valid,
  input  logic [DW-1:0]      rx_in_data,
  output logic [DW-1:0]      rx_rdata,
  output logic               rx_rvalid,
  input  logic               rx_rready,
  output logic [AVAIL_W-1:0] rx_avail
);
  localparam int TXA = $clog2(TX_DEPTH);
  localparam int RXA = $clog2(RX_DEPTH);
  localparam logic [TXA:0] TX_FULL = (TXA+1)'(TX_DEPTH);
  localparam logic [RXA:0] RX_FULL = (RXA+1)'(RX_DEPTH);
  localparam logic [7:0] STS_MASK = 8'h51;

  logic [DW-1:0] tx_mem [TX_DEPTH];
  logic [DW-1:0] rx_mem [RX_DEPTH];
  logic [TXA-1:0] tx_wp, tx_rp;
  logic [RXA-1:0] rx_wp, rx_rp;
  logic [TXA:0] tx_cnt;
  logic [RXA:0] rx_cnt;
  logic [7:0] sts_q;

  wire tx_empty = (tx_cnt == '0);
  wire rx_empty = (rx_cnt == '0);
  wire tx_push  = tx_wvalid && tx_wready;
  wire tx_pop   = tx_req && !tx_empty && !tx_flush;
  wire tx_under = tx_req && tx_empty && !tx_flush;
  wire rx_push  = rx_in_valid && (rx_cnt != RX_FULL) && !rx_flush;
  wire rx_pop   = rx_rready && !rx_empty && !rx_flush;

  assign tx_wready = (tx_cnt != TX_FULL) && !tx_flush;
  assign tx_free   = FREE_W'(TX_FULL - tx_cnt);
  assign rx_avail  = AVAIL_W'(rx_cnt);
  assign rx_rvalid = !rx_empty && !rx_flush;
  assign rx_rdata  = rx_mem[rx_rp];

  wire thr_hit = tx_pop &&
    ((FREE_W+1)'(tx_free) + (FREE_W+1)'(1) >= (FREE_W+1)'(tx_level));
  wire avail_hit = !rx_empty && !rx_flush;
  wire [7:0] sts_set = {1'b0, tx_under, 1'b0, thr_hit, 3'b000, avail_hit};
  wire [7:0] clr_mask = sts_clr_we ? sts_clr : 8'h00;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (TXA+1)'(tx_push) - (TXA+1)'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (RXA+1)'(rx_push) - (RXA+1)'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tx_word <= '0;
    else if (tx_req) tx_word <= tx_pop ? tx_mem[tx_rp] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_set | (sts_q & ~clr_mask)) & STS_MASK;
  end

  assign sts    = sts_q;
  assign irq    = |(sts_q & irq_en & STS_MASK);
  assign tx_drq = irq_en[7] && (tx_free >= FREE_W'(tx_level));
  assign rx_drq = irq_en[3] && !rx_empty;
endmodule

module audio_fifo_irq_chk #(
  parameter int DW       = 32,
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 32,
  parameter int FREE_W   = 8,
  parameter int AVAIL_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_flush,
  input logic               rx_flush,
  input logic               tx_req,
  input logic               sts_clr_we,
  input logic [7:0]         sts_clr,
  input logic [7:0]         irq_en,
  input logic [7:0]         sts,
  input logic               irq,
  input logic [FREE_W-1:0]  tx_free,
  input logic [AVAIL_W-1:0] rx_avail,
  input logic [DW-1:0]      tx_word
);
  localparam logic [FREE_W-1:0]  TXF = FREE_W'(TX_DEPTH);
  localparam logic [AVAIL_W-1:0] RXF = AVAIL_W'(RX_DEPTH);

  AST_TX_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_free <= TXF); // R2
  AST_RX_AVAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail <= RXF); // R3
  AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_free == TXF); // R4
  AST_RX_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush && !sts[0] |=> rx_avail == '0 && !sts[0]); // R4
  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_flush && tx_free == TXF |=> sts[6] && tx_word == '0); // R5
  AST_W1C_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr_we && sts_clr[6] && !(tx_req && tx_free == TXF && !tx_flush) |=> !sts[6]); // R8
  AST_STS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & 8'hAE) == 8'h00); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en & 8'h51) == 8'h00 |-> !irq); // R9
endmodule

bind audio_fifo_irq audio_fifo_irq_chk #(
  .DW(DW), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .FREE_W(FREE_W), .AVAIL_W(AVAIL_W)
) chk (
  .clk(clk), .rst_n(rst_n), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .tx_req(tx_req), .sts_clr_we(sts_clr_we), .sts_clr(sts_clr), .irq_en(irq_en),
  .sts(sts), .irq(irq), .tx_free(tx_free), .rx_avail(rx_avail), .tx_word(tx_word)
);

// File: tb/audio_fifo_irq_test.sv
module audio_fifo_irq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] tx_level = '0;
  logic [7:0] irq_en = '0;
  logic tx_flush = 1'b0, rx_flush = 1'b0, sts_clr_we = 1'b0;
  logic [7:0] sts_clr = '0;
  logic [7:0] sts;
  logic irq, tx_drq, rx_drq, tx_wready, rx_rvalid;
  logic tx_wvalid = 1'b0, tx_req = 1'b0, rx_in_valid = 1'b0, rx_rready = 1'b0;
  logic [31:0] tx_wdata = '0, rx_in_data = '0;
  logic [31:0] tx_word, rx_rdata;
  logic [7:0] tx_free;
  logic [5:0] rx_avail;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_fifo_irq uut (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .irq_en(irq_en),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .sts_clr_we(sts_clr_we), .sts_clr(sts_clr),
    .sts(sts), .irq(irq), .tx_drq(tx_drq), .rx_drq(rx_drq),
    .tx_wvalid(tx_wvalid), .tx_wdata(tx_wdata), .tx_wready(tx_wready), .tx_free(tx_free),
    .tx_req(tx_req), .tx_word(tx_word), .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .rx_rdata(rx_rdata), .rx_rvalid(rx_rvalid), .rx_rready(rx_rready), .rx_avail(rx_avail)
  );

  // op: 0 tx write, 1 serializer pull, 2 rx arrive, 3 rx pop
  localparam int NV = 12;
  localparam logic [79:0] VEC [NV] = '{
    {2'd0, 32'h0000_00A1, 8'd127, 6'd0, 32'h0},
    {2'd0, 32'h0000_00B2, 8'd126, 6'd0, 32'h0},
    {2'd0, 32'h0000_00C3, 8'd125, 6'd0, 32'h0},
    {2'd1, 32'h0,         8'd126, 6'd0, 32'h0000_00A1},
    {2'd2, 32'h0000_00D4, 8'd126, 6'd1, 32'h0},
    {2'd2, 32'h0000_00E5, 8'd126, 6'd2, 32'h0},
    {2'd1, 32'h0,         8'd127, 6'd2, 32'h0000_00B2},
    {2'd3, 32'h0,         8'd127, 6'd1, 32'h0000_00D4},
    {2'd0, 32'h0000_00F6, 8'd126, 6'd1, 32'h0},
    {2'd1, 32'h0,         8'd127, 6'd1, 32'h0000_00C3},
    {2'd1, 32'h0,         8'd128, 6'd1, 32'h0000_00F6},
    {2'd3, 32'h0,         8'd128, 6'd0, 32'h0000_00E5}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tx_wvalid = 0; tx_req = 0; rx_in_valid = 0; rx_rready = 0;
    tx_flush = 0; rx_flush = 0; sts_clr_we = 0; sts_clr = '0;
  endtask

  task automatic clear_all();
    sts_clr_we = 1; sts_clr = 8'hFF;
    step();
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 free", 32'(tx_free), 32'd128);
    chk("R1 avail", 32'(rx_avail), 32'd0);
    chk("R1 sts", 32'(sts), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 word", tx_word, 32'd0);
    chk("R1 wready", 32'(tx_wready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      idle();
      case (VEC[i][79:78])
        2'd0: begin tx_wvalid = 1; tx_wdata = VEC[i][77:46]; end
        2'd1: tx_req = 1;
        2'd2: begin rx_in_valid = 1; rx_in_data = VEC[i][77:46]; end
        default: begin
          rx_rready = 1;
          chk("R3 rx order", rx_rdata, VEC[i][31:0]);
        end
      endcase
      step();
      chk("R2 free count", 32'(tx_free), 32'(VEC[i][45:38]));
      chk("R3 avail count", 32'(rx_avail), 32'(VEC[i][37:32]));
      if (VEC[i][79:78] == 2'd1) chk("R2 tx order", tx_word, VEC[i][31:0]);
    end
    idle();

    // R7 / R8: RX data present bit
    clear_all();
    chk("R8 cleared", 32'(sts), 32'd0);
    rx_in_valid = 1; rx_in_data = 32'h77;
    step(); idle();
    step();
    chk("R7 rx present", 32'(sts[0]), 32'd1);
    rx_rready = 1;
    step(); idle();
    chk("R7 sticky", 32'(sts[0]), 32'd1);
    clear_all();
    chk("R8 w1c rx", 32'(sts[0]), 32'd0);

    // R5 underrun
    tx_req = 1;
    step(); idle();
    chk("R5 underrun bit", 32'(sts[6]), 32'd1);
    chk("R5 zero word", tx_word, 32'd0);

    // R9 interrupt masking
    irq_en = 8'h00; #1;
    chk("R9 masked", 32'(irq), 32'd0);
    irq_en = 8'h40; #1;
    chk("R9 enabled", 32'(irq), 32'd1);
    irq_en = 8'h11; #1;
    chk("R9 other enables", 32'(irq), 32'd0);
    irq_en = 8'h00;

    // R8 set wins over clear, spare bits
    tx_req = 1; sts_clr_we = 1; sts_clr = 8'h40;
    step(); idle();
    chk("R8 set wins", 32'(sts[6]), 32'd1);
    sts_clr_we = 1; sts_clr = 8'h40;
    step(); idle();
    chk("R8 w1c underrun", 32'(sts[6]), 32'd0);
    sts_clr_we = 1; sts_clr = 8'hFF;
    step(); idle();
    chk("R8 spare bits", 32'(sts & 8'hAE), 32'd0);

    // R6 threshold
    tx_level = 7'd126;
    for (int i = 0; i < 4; i++) begin
      tx_wvalid = 1; tx_wdata = 32'(i);
      step();
    end
    idle();
    clear_all();
    tx_req = 1;
    step(); idle();
    chk("R6 below level", 32'(sts[4]), 32'd0);
    tx_req = 1;
    step(); idle();
    chk("R6 level reached", 32'(sts[4]), 32'd1);
    tx_req = 1;
    step(); step(); idle();

    // R10 DMA requests
    irq_en = 8'h88;
    #1;
    chk("R10 tx drq", 32'(tx_drq), 32'd1);
    chk("R10 rx drq idle", 32'(rx_drq), 32'd0);
    rx_in_valid = 1; rx_in_data = 32'h55;
    step(); idle();
    chk("R10 rx drq", 32'(rx_drq), 32'd1);
    rx_rready = 1;
    step(); idle();
    tx_level = 7'd127;
    tx_wvalid = 1; step(); step(); idle();
    chk("R10 tx drq low", 32'(tx_drq), 32'd0);
    tx_req = 1; step(); step(); idle();
    irq_en = 8'h00;

    // R2 full transmit queue
    for (int i = 0; i < 128; i++) begin
      tx_wvalid = 1; tx_wdata = 32'(i + 1000);
      step();
    end
    chk("R2 full free", 32'(tx_free), 32'd0);
    chk("R2 full wready", 32'(tx_wready), 32'd0);
    tx_wdata = 32'hDEAD;
    step(); idle();
    chk("R2 write ignored", 32'(tx_free), 32'd0);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      tx_req = 1;
      step();
      if (tx_word !== 32'(i + 1000)) bad++;
    end
    idle();
    chk("R2 full drain order", 32'(bad), 32'd0);
    tx_req = 1; step(); idle();
    chk("R2 no extra word", tx_word, 32'd0);

    // R3 full receive queue
    for (int i = 0; i < 33; i++) begin
      rx_in_valid = 1; rx_in_data = 32'(i + 100);
      step();
    end
    idle();
    chk("R3 full avail", 32'(rx_avail), 32'd32);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      rx_rready = 1;
      if (rx_rdata !== 32'(i + 100)) bad++;
      step();
    end
    chk("R3 full drain order", 32'(bad), 32'd0);
    step(); idle();
    chk("R3 empty pop", 32'(rx_avail), 32'd0);
    chk("R3 rvalid low", 32'(rx_rvalid), 32'd0);

    // R4 flush
    for (int i = 0; i < 5; i++) begin
      tx_wvalid = 1; tx_wdata = 32'(i);
      rx_in_valid = 1; rx_in_data = 32'(i);
      step();
    end
    idle();
    tx_flush = 1; rx_flush = 1; tx_wvalid = 1; sts_clr_we = 1; sts_clr = 8'hFF;
    step(); idle();
    chk("R4 tx emptied", 32'(tx_free), 32'd128);
    chk("R4 rx emptied", 32'(rx_avail), 32'd0);
    step();
    chk("R4 no status", 32'(sts), 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule